// File: doc/BRIEF.md
# DDR Mode Register Load Checker and Store

This block is the device-side logic that receives mode-register load commands for a DDR SDRAM. It keeps the base register settings (CAS latency, burst type, burst length) and the extended register settings (DLL enable, reduced output drive, QFC enable), and it presents them as plain outputs. The other side of the chip uses these outputs to configure its read path.

Each load is decoded from the two bank-select bits and the thirteen address bits. The block also checks whether the load is legal. It rejects reserved operating-mode codes, reserved latency codes, extended loads issued while banks are busy, and loads that arrive too soon after the previous one. Any rejected load leaves the stored state untouched. The block also watches the order of loads. It warns when a DLL enable is not followed by a DLL reset, and it gives an advisory when a DLL reset is not followed by a normal-mode load.

Every flag is a one-cycle pulse registered on the clock edge that samples the command. Stored settings change on that same edge. The asynchronous active-low reset is released synchronously through two flops inside the block.

Top module: `ddr_mode_ctl`

## Requirements
- R1: After reset the outputs read CAS latency code 110 (2.5 clocks), burst type 0, burst length code 001, DLL enabled, full drive, QFC disabled, busy low and every flag low.
- R2: An accepted base load (ba=00, addr[12:7]=000000) stores addr[6:4] as the CAS code, addr[3] as the burst type and addr[2:0] as the burst length code. It raises no flag.
- R3: A base load with addr[8]=1 and addr[12:9], addr[7] zero is a DLL reset. It stores the same fields as R2 and pulses dll_reset_pulse for exactly one cycle.
- R4: A base load whose addr[12:7] is neither 000000 nor 000010 pulses err_reserved_mode and changes no stored setting.
- R5: On a base load, a CAS code other than 010 (2 clocks) or 110 (2.5 clocks) pulses err_cas and changes no stored setting. The stored CAS code is always one of those two values.
- R6: An extended load (ba=01) made with banks_idle=1 and burst_active=0 stores DLL enable as the inverse of addr[0], reduced drive from addr[1] and QFC enable from addr[2].
- R7: An extended load made with banks_idle=0 or burst_active=1 pulses err_emr_busy and leaves the extended settings unchanged.
- R8: After an accepted extended load with addr[0]=0, if the next load taken is anything other than an accepted DLL reset, warn_dll_no_reset pulses.
- R9: After an accepted DLL reset, if the next load taken is anything other than an accepted normal-mode base load, adv_no_normal pulses.
- R10: After an accepted load, busy stays high for MRD_CYCLES cycles. A load that arrives while busy is high pulses err_too_soon. It is ignored and does not count as the next load for R8 or R9.
- R11: A command with ba[1]=1 is ignored. It changes no setting, raises no flag and does not start busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Load command strobe, one cycle per command |
| ba | input | 2 | Bank-select bits that pick the register |
| addr | input | 13 | Address bits carrying the register contents |
| banks_idle | input | 1 | High when all banks are idle |
| burst_active | input | 1 | High while a burst is in progress |
| cas_lat | output | 3 | Stored CAS latency code |
| burst_type | output | 1 | Stored burst type |
| burst_len | output | 3 | Stored burst length code |
| dll_en | output | 1 | DLL enable setting |
| drive_half | output | 1 | Reduced output drive selected |
| qfc_en | output | 1 | QFC output enable setting |
| dll_reset_pulse | output | 1 | One-cycle pulse on an accepted DLL reset |
| busy | output | 1 | High during the wait after an accepted load |
| err_reserved_mode | output | 1 | Reserved operating-mode code pulse |
| err_cas | output | 1 | Reserved CAS code pulse |
| err_emr_busy | output | 1 | Extended load while banks are busy pulse |
| err_too_soon | output | 1 | Load during busy pulse |
| warn_dll_no_reset | output | 1 | DLL enable not followed by DLL reset pulse |
| adv_no_normal | output | 1 | DLL reset not followed by normal load pulse |

## Verification
The assertions take it that cmd_valid lasts one cycle per command. Their hold checks use $stable, so they compare against the previous cycle, and they assume nothing else changes the registers on a rejected edge. The pulse checks assume that an accepted DLL reset always starts busy, which means MRD_CYCLES is at least one. The bench runs with MRD_CYCLES set to 2. It leaves MRD_CYCLES idle cycles after each command, except in the single scenario that sends a load during busy on purpose. It drives each command for one cycle only.

// File: rtl/ddr_mode_pkg.sv
package ddr_mode_pkg;

  localparam int ADDR_W = 13;

  typedef enum logic [1:0] {
    SEL_BASE = 2'b00,
    SEL_EXT  = 2'b01,
    SEL_NONE = 2'b10
  } reg_sel_e;

  typedef enum logic [1:0] {
    OP_NORMAL = 2'b00,
    OP_DLLRST = 2'b01,
    OP_RSVD   = 2'b10
  } op_e;

  localparam logic [2:0] CL_TWO      = 3'b010;
  localparam logic [2:0] CL_TWO_HALF = 3'b110;

  typedef struct packed {
    logic [2:0] cl;
    logic       bt;
    logic [2:0] bl;
  } base_t;

  typedef struct packed {
    logic dll_en;
    logic drv_half;
    logic qfc_en;
  } ext_t;

  localparam base_t BASE_RST = '{cl: CL_TWO_HALF, bt: 1'b0, bl: 3'b001};
  localparam ext_t  EXT_RST  = '{dll_en: 1'b1, drv_half: 1'b0, qfc_en: 1'b0};

endpackage

// File: rtl/mrs_decode.sv
module mrs_decode
  import ddr_mode_pkg::*;
(
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output op_e               op,
  output logic              cas_ok,
  output base_t             base_d,
  output ext_t              ext_d
);

  logic [5:0] mode_bits;

  always_comb begin
    mode_bits = addr[12:7];
    if (ba[1])      sel = SEL_NONE;
    else if (ba[0]) sel = SEL_EXT;
    else            sel = SEL_BASE;

    if (mode_bits == 6'b000000)      op = OP_NORMAL;
    else if (mode_bits == 6'b000010) op = OP_DLLRST;
    else                             op = OP_RSVD;

    base_d.cl = addr[6:4];
    base_d.bt = addr[3];
    base_d.bl = addr[2:0];
    cas_ok    = (addr[6:4] == CL_TWO) || (addr[6:4] == CL_TWO_HALF);

    ext_d.dll_en   = ~addr[0];
    ext_d.drv_half = addr[1];
    ext_d.qfc_en   = addr[2];
  end

endmodule

// File: rtl/mode_regs.sv
module mode_regs
  import ddr_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  base_we,
  input  logic  ext_we,
  input  base_t base_d,
  input  ext_t  ext_d,
  output base_t base_q,
  output ext_t  ext_q
);

  base_t base_nx;
  ext_t  ext_nx;

  always_comb begin
    base_nx = base_q;
    ext_nx  = ext_q;
    if (base_we) base_nx = base_d;
    if (ext_we)  ext_nx  = ext_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= BASE_RST;
      ext_q  <= EXT_RST;
    end else begin
      base_q <= base_nx;
      ext_q  <= ext_nx;
    end
  end

endmodule

// File: rtl/mrs_seq_check.sv
module mrs_seq_check
  import ddr_mode_pkg::*;
#(
  parameter int MRD_CYCLES = 2
)(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_valid,
  input  reg_sel_e sel,
  input  op_e      op,
  input  logic     cas_ok,
  input  logic     dll_en_req,
  input  logic     banks_idle,
  input  logic     burst_active,
  output logic     base_we,
  output logic     ext_we,
  output logic     busy,
  output logic     dll_reset_pulse,
  output logic     err_reserved_mode,
  output logic     err_cas,
  output logic     err_emr_busy,
  output logic     err_too_soon,
  output logic     warn_dll_no_reset,
  output logic     adv_no_normal
);

  localparam int CNT_W = (MRD_CYCLES < 1) ? 1 : $clog2(MRD_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic need_rst_q, need_rst_d;
  logic need_norm_q, need_norm_d;
  logic [6:0] flag_q, flag_d;
  logic load, take, is_base, is_ext, base_ok, ext_ok, rst_ok, norm_ok;

  assign busy = (cnt_q != '0);

  always_comb begin
    load    = cmd_valid && (sel != SEL_NONE);
    take    = load && !busy;
    is_base = (sel == SEL_BASE);
    is_ext  = (sel == SEL_EXT);
    base_ok = take && is_base && (op != OP_RSVD) && cas_ok;
    ext_ok  = take && is_ext && banks_idle && !burst_active;
    rst_ok  = base_ok && (op == OP_DLLRST);
    norm_ok = base_ok && (op == OP_NORMAL);
    base_we = base_ok;
    ext_we  = ext_ok;

    if (base_ok || ext_ok) cnt_d = CNT_W'(MRD_CYCLES);
    else if (busy)         cnt_d = cnt_q - 1'b1;
    else                   cnt_d = cnt_q;

    need_rst_d  = take ? (ext_ok && dll_en_req) : need_rst_q;
    need_norm_d = take ? rst_ok : need_norm_q;

    flag_d[6] = rst_ok;
    flag_d[5] = take && is_base && (op == OP_RSVD);
    flag_d[4] = take && is_base && !cas_ok;
    flag_d[3] = take && is_ext && !(banks_idle && !burst_active);
    flag_d[2] = load && busy;
    flag_d[1] = take && need_rst_q && !rst_ok;
    flag_d[0] = take && need_norm_q && !norm_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      need_rst_q  <= 1'b0;
      need_norm_q <= 1'b0;
      flag_q      <= '0;
    end else begin
      cnt_q       <= cnt_d;
      need_rst_q  <= need_rst_d;
      need_norm_q <= need_norm_d;
      flag_q      <= flag_d;
    end
  end

  assign dll_reset_pulse   = flag_q[6];
  assign err_reserved_mode = flag_q[5];
  assign err_cas           = flag_q[4];
  assign err_emr_busy      = flag_q[3];
  assign err_too_soon      = flag_q[2];
  assign warn_dll_no_reset = flag_q[1];
  assign adv_no_normal     = flag_q[0];

endmodule

// File: rtl/ddr_mode_ctl.sv
module ddr_mode_ctl
  import ddr_mode_pkg::*;
#(
  parameter int MRD_CYCLES = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        ba,
  input  logic [ADDR_W-1:0] addr,
  input  logic              banks_idle,
  input  logic              burst_active,
  output logic [2:0]        cas_lat,
  output logic              burst_type,
  output logic [2:0]        burst_len,
  output logic              dll_en,
  output logic              drive_half,
  output logic              qfc_en,
  output logic              dll_reset_pulse,
  output logic              busy,
  output logic              err_reserved_mode,
  output logic              err_cas,
  output logic              err_emr_busy,
  output logic              err_too_soon,
  output logic              warn_dll_no_reset,
  output logic              adv_no_normal
);

  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  reg_sel_e sel;
  op_e      op;
  logic     cas_ok, base_we, ext_we;
  base_t    base_d, base_q;
  ext_t     ext_d, ext_q;

  mrs_decode u_dec (
    .ba     (ba),
    .addr   (addr),
    .sel    (sel),
    .op     (op),
    .cas_ok (cas_ok),
    .base_d (base_d),
    .ext_d  (ext_d)
  );

  mrs_seq_check #(.MRD_CYCLES(MRD_CYCLES)) u_seq (
    .clk               (clk),
    .rst_n             (rst_int_n),
    .cmd_valid         (cmd_valid),
    .sel               (sel),
    .op                (op),
    .cas_ok            (cas_ok),
    .dll_en_req        (ext_d.dll_en),
    .banks_idle        (banks_idle),
    .burst_active      (burst_active),
    .base_we           (base_we),
    .ext_we            (ext_we),
    .busy              (busy),
    .dll_reset_pulse   (dll_reset_pulse),
    .err_reserved_mode (err_reserved_mode),
    .err_cas           (err_cas),
    .err_emr_busy      (err_emr_busy),
    .err_too_soon      (err_too_soon),
    .warn_dll_no_reset (warn_dll_no_reset),
    .adv_no_normal     (adv_no_normal)
  );

  mode_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .base_we (base_we),
    .ext_we  (ext_we),
    .base_d  (base_d),
    .ext_d   (ext_d),
    .base_q  (base_q),
    .ext_q   (ext_q)
  );

  assign cas_lat    = base_q.cl;
  assign burst_type = base_q.bt;
  assign burst_len  = base_q.bl;
  assign dll_en     = ext_q.dll_en;
  assign drive_half = ext_q.drv_half;
  assign qfc_en     = ext_q.qfc_en;

endmodule

// File: rtl/ddr_mode_ctl_chk.sv
module ddr_mode_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] ba,
  input logic [2:0] cas_lat,
  input logic       burst_type,
  input logic [2:0] burst_len,
  input logic       dll_en,
  input logic       drive_half,
  input logic       qfc_en,
  input logic       dll_reset_pulse,
  input logic       busy,
  input logic       err_reserved_mode,
  input logic       err_emr_busy,
  input logic       err_too_soon
);

  assert_cas_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_lat == 3'b010) || (cas_lat == 3'b110));

  assert_rsvd_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_reserved_mode |-> ($stable(cas_lat) && $stable(burst_type) && $stable(burst_len)));

  assert_emr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_emr_busy |-> ($stable(dll_en) && $stable(drive_half) && $stable(qfc_en)));

  assert_soon_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_too_soon |-> $past(busy));

  assert_pulse_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dll_reset_pulse |-> busy);

  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dll_reset_pulse |=> !dll_reset_pulse);

  assert_ba1_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && ba[1]) |=> ($stable(cas_lat) && $stable(dll_en) && $stable(qfc_en)));

endmodule

bind ddr_mode_ctl ddr_mode_ctl_chk u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .cmd_valid         (cmd_valid),
  .ba                (ba),
  .cas_lat           (cas_lat),
  .burst_type        (burst_type),
  .burst_len         (burst_len),
  .dll_en            (dll_en),
  .drive_half        (drive_half),
  .qfc_en            (qfc_en),
  .dll_reset_pulse   (dll_reset_pulse),
  .busy              (busy),
  .err_reserved_mode (err_reserved_mode),
  .err_emr_busy      (err_emr_busy),
  .err_too_soon      (err_too_soon)
);

// File: tb/tb_ddr_mode_ctl.sv
module tb_ddr_mode_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int MRD = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  ba = 2'b00;
  logic [12:0] addr = '0;
  logic        banks_idle = 1'b1;
  logic        burst_active = 1'b0;
  logic [2:0]  cas_lat, burst_len;
  logic        burst_type, dll_en, drive_half, qfc_en, dll_reset_pulse, busy;
  logic        err_reserved_mode, err_cas, err_emr_busy, err_too_soon;
  logic        warn_dll_no_reset, adv_no_normal;

  int checks = 0;
  int errors = 0;

  logic [2:0] e_cl, e_bl;
  logic       e_bt, e_dll, e_drv, e_qfc;

  ddr_mode_ctl #(.MRD_CYCLES(MRD)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .ba(ba), .addr(addr),
    .banks_idle(banks_idle), .burst_active(burst_active),
    .cas_lat(cas_lat), .burst_type(burst_type), .burst_len(burst_len),
    .dll_en(dll_en), .drive_half(drive_half), .qfc_en(qfc_en),
    .dll_reset_pulse(dll_reset_pulse), .busy(busy),
    .err_reserved_mode(err_reserved_mode), .err_cas(err_cas),
    .err_emr_busy(err_emr_busy), .err_too_soon(err_too_soon),
    .warn_dll_no_reset(warn_dll_no_reset), .adv_no_normal(adv_no_normal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // flag order: pulse, reserved, cas, emr_busy, too_soon, warn, adv
  task automatic chk_flags(input string tag, input logic [6:0] exp);
    chk({tag, " flags"}, {dll_reset_pulse, err_reserved_mode, err_cas, err_emr_busy,
                          err_too_soon, warn_dll_no_reset, adv_no_normal}, exp);
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " base"}, {cas_lat, burst_type, burst_len}, {e_cl, e_bt, e_bl});
    chk({tag, " ext"}, {dll_en, drive_half, qfc_en}, {e_dll, e_drv, e_qfc});
  endtask

  task automatic send(input logic [1:0] b, input logic [12:0] a, input logic idle, input logic bst);
    ba = b; addr = a; banks_idle = idle; burst_active = bst; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; banks_idle = 1'b1; burst_active = 1'b0;
  endtask

  task automatic gap();
    repeat (MRD) @(negedge clk);
  endtask

  task automatic t_reset();
    e_cl = 3'b110; e_bt = 1'b0; e_bl = 3'b001; e_dll = 1'b1; e_drv = 1'b0; e_qfc = 1'b0;
    chk_state("R1 reset");
    chk_flags("R1 reset", 7'b0);
    chk("R1 busy", busy, 0);
  endtask

  task automatic t_normal();
    send(2'b00, 13'h02B, 1'b1, 1'b0);
    e_cl = 3'b010; e_bt = 1'b1; e_bl = 3'b011;
    chk_state("R2 normal");
    chk_flags("R2 normal", 7'b0);
    chk("R10 busy after load", busy, 1);
    gap();
    chk("R10 busy ends", busy, 0);
  endtask

  task automatic t_dll_reset();
    send(2'b00, 13'h162, 1'b1, 1'b0);
    e_cl = 3'b110; e_bt = 1'b0; e_bl = 3'b010;
    chk_state("R3 dll reset");
    chk_flags("R3 dll reset", 7'b1000000);
    gap();
    chk("R3 pulse one cycle", dll_reset_pulse, 0);
    send(2'b00, 13'h022, 1'b1, 1'b0);
    e_cl = 3'b010;
    chk_state("R9 normal after reset");
    chk_flags("R9 normal after reset", 7'b0);
    gap();
  endtask

  task automatic t_reserved();
    send(2'b00, 13'h0A2, 1'b1, 1'b0);
    chk_flags("R4 A7 set", 7'b0100000);
    chk_state("R4 A7 set");
    gap();
    send(2'b00, 13'h1162, 1'b1, 1'b0);
    chk_flags("R4 A12 set", 7'b0100000);
    chk_state("R4 A12 set");
    gap();
    send(2'b00, 13'h0362, 1'b1, 1'b0);
    chk_flags("R4 A9 set", 7'b0100000);
    chk_state("R4 A9 set");
    chk("R4 no busy", busy, 0);
    gap();
  endtask

  task automatic t_cas();
    send(2'b00, 13'h032, 1'b1, 1'b0);
    chk_flags("R5 cas 011", 7'b0010000);
    chk_state("R5 cas 011");
    gap();
    send(2'b00, 13'h102, 1'b1, 1'b0);
    chk_flags("R5 cas 000 with dll reset", 7'b0010000);
    chk_state("R5 cas 000");
    gap();
  endtask

  task automatic t_emr();
    send(2'b01, 13'h006, 1'b1, 1'b0);
    e_dll = 1'b1; e_drv = 1'b1; e_qfc = 1'b1;
    chk_state("R6 ext load");
    chk_flags("R6 ext load", 7'b0);
    gap();
    send(2'b00, 13'h162, 1'b1, 1'b0);
    e_cl = 3'b110; e_bt = 1'b0; e_bl = 3'b010;
    chk_flags("R8 reset follows enable", 7'b1000000);
    gap();
    send(2'b00, 13'h02B, 1'b1, 1'b0);
    e_cl = 3'b010; e_bt = 1'b1; e_bl = 3'b011;
    chk_flags("R9 normal follows reset", 7'b0);
    chk_state("R2 normal again");
    gap();
    send(2'b01, 13'h001, 1'b1, 1'b0);
    e_dll = 1'b0; e_drv = 1'b0; e_qfc = 1'b0;
    chk_state("R6 dll disable");
    gap();
    send(2'b00, 13'h02B, 1'b1, 1'b0);
    chk_flags("R8 no warn after disable", 7'b0);
    gap();
  endtask

  task automatic t_emr_busy();
    send(2'b01, 13'h006, 1'b0, 1'b0);
    chk_flags("R7 banks not idle", 7'b0001000);
    chk_state("R7 banks not idle");
    gap();
    send(2'b01, 13'h006, 1'b1, 1'b1);
    chk_flags("R7 burst active", 7'b0001000);
    chk_state("R7 burst active");
    gap();
  endtask

  task automatic t_warn();
    send(2'b01, 13'h000, 1'b1, 1'b0);
    e_dll = 1'b1;
    chk_state("R6 dll enable");
    gap();
    send(2'b00, 13'h02B, 1'b1, 1'b0);
    chk_flags("R8 warn", 7'b0000010);
    chk_state("R8 normal still stored");
    gap();
    send(2'b00, 13'h02B, 1'b1, 1'b0);
    chk_flags("R8 warn once", 7'b0);
    gap();
  endtask

  task automatic t_adv();
    send(2'b00, 13'h162, 1'b1, 1'b0);
    e_cl = 3'b110; e_bt = 1'b0; e_bl = 3'b010;
    chk_flags("R3 reset pulse", 7'b1000000);
    gap();
    send(2'b01, 13'h001, 1'b1, 1'b0);
    e_dll = 1'b0;
    chk_flags("R9 advisory", 7'b0000001);
    chk_state("R9 ext stored");
    gap();
  endtask

  task automatic t_busy();
    send(2'b00, 13'h02B, 1'b1, 1'b0);
    e_cl = 3'b010; e_bt = 1'b1; e_bl = 3'b011;
    send(2'b00, 13'h062, 1'b1, 1'b0);
    chk_flags("R10 too soon", 7'b0000100);
    chk_state("R10 too soon ignored");
    gap();
    chk("R10 busy clears", busy, 0);
    send(2'b00, 13'h062, 1'b1, 1'b0);
    e_cl = 3'b110; e_bt = 1'b0; e_bl = 3'b010;
    chk_flags("R10 spaced load", 7'b0);
    chk_state("R10 spaced load");
    gap();
  endtask

  task automatic t_ba1();
    send(2'b10, 13'h1FFF, 1'b1, 1'b0);
    chk_flags("R11 ba 10", 7'b0);
    chk("R11 no busy", busy, 0);
    chk_state("R11 ba 10");
    gap();
    send(2'b11, 13'h0000, 1'b0, 1'b1);
    chk_flags("R11 ba 11", 7'b0);
    chk_state("R11 ba 11");
    gap();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_normal();
    t_dll_reset();
    t_reserved();
    t_cas();
    t_emr();
    t_emr_busy();
    t_warn();
    t_adv();
    t_busy();
    t_ba1();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule